// File: doc/BRIEF.md
# ISA I/O address qualification decoder

This block watches host I/O read and write strobes on an ISA-style bus and turns each qualified cycle into a single chip select for one of several internal register windows, together with the register offset inside that window. One window is the configuration port pair, an index register and a data register at the next address up. The other windows are 16-byte blocks whose bases come in from programmable registers elsewhere in the chip.

The address is captured once per cycle, at the clock on which a strobe is first seen low. The whole 11-bit captured value is used for the decode. Cycles that run while the DMA address-enable line is high never select anything. When external qualification is switched on, a select is also gated by an active-low chip-select input, so that board logic can account for address bits above bit 10. A strap input is sampled while reset is held. The last value seen before reset is released picks the configuration base, and that base stays fixed until the next reset.

All inputs are assumed synchronous to the block clock. Selects and offset are registered outputs.

Top module: `io_qual_decoder`

## Requirements
- R1: The address used for a cycle is the one present on the first clock at which a strobe is low. Later address changes during the same strobe do not alter the select or the offset.
- R2: All 11 address bits take part in every comparison. An address that differs from a window address only in bit 10, such as 0x7F0 against 0x3F0, selects nothing.
- R3: While the address-enable input is high on a sampled clock, no select is asserted on the following clock.
- R4: With qualification enabled, a select is asserted only while the chip-select input is low. With qualification disabled, the chip-select input has no effect.
- R5: A strap value of 0 seen on the last clock of reset places the configuration pair at 0x3F0 and 0x3F1. A value of 1 places it at 0x370 and 0x371. Strap changes after reset release do not move the pair.
- R6: General window k is hit by any address whose bits 10..4 equal bits 10..4 of its base. Base bits 3..0 are ignored.
- R7: At most one select is asserted at a time. Priority runs configuration first, then window 0, window 1 and window 2.
- R8: A select asserts at the clock edge that samples the strobe low and clears at the first edge that samples both strobes high. Read and write strobes act alike. All outputs are 0 during reset.
- R9: While a select is asserted, the offset equals bits 3..0 of the captured address. Otherwise the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset; the strap is sampled while it is high |
| addr | input | 11 | Host I/O address |
| ior_n | input | 1 | Active-low read strobe |
| iow_n | input | 1 | Active-low write strobe |
| aen | input | 1 | DMA address enable; high blocks all selects |
| cs_n | input | 1 | Active-low external chip select |
| cs_qual_en | input | 1 | 1 makes selects depend on cs_n |
| cfg_strap | input | 1 | Configuration base strap (0: 0x3F0, 1: 0x370) |
| win_base | input | 33 | Window bases, window k in bits 11k+10..11k |
| cfg_sel | output | 1 | Configuration index/data select |
| win_sel | output | 3 | General window selects, bit k for window k |
| reg_offset | output | 4 | Register offset within the selected window |

## Verification
Two functions can meet in the same cycle: the configuration pair can overlap a general window, and two general windows can cover the same block, so the priority logic and the qualification gating act together on one address. The bench sets up such overlaps on purpose. It places window 2 over the configuration block and gives windows 0 and 1 the same base. It then sweeps all 2048 addresses under both strap values and compares the select vector and the offset against arithmetic expectations. Separate directed cycles raise the address-enable or chip-select inputs, or change the address, while a strobe is already low. They check that the blocking or the holding takes effect on the next clock.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
   parameter int unsigned IODEC_ADDR_W   = 11;
   parameter int unsigned IODEC_WIN_LOG2 = 4;
   parameter logic [10:0] IODEC_CFG_LO   = 11'h3F0;
   parameter logic [10:0] IODEC_CFG_HI   = 11'h370;

   // select slot order, lowest index wins
   typedef enum logic [1:0] {
      SLOT_CFG  = 2'd0,
      SLOT_WIN0 = 2'd1,
      SLOT_WIN1 = 2'd2,
      SLOT_WIN2 = 2'd3
   } iodec_slot_e;
endpackage

// File: rtl/iodec_capture.sv
module iodec_capture #(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic [ADDR_W-1:0] addr_eff
);
   logic              active_q;
   logic              lead;
   logic [ADDR_W-1:0] addr_lat;

   assign active   = ~ior_n | ~iow_n;
   assign lead     = active & ~active_q;
   assign addr_eff = lead ? addr : addr_lat;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         addr_lat <= '0;
      end else begin
         active_q <= active;
         if (lead) addr_lat <= addr;
      end
   end

   // R1: captured address frozen while the strobe stays low
   assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (active && active_q) |=> $stable(addr_lat) || !active_q);
endmodule

// File: rtl/iodec_match.sv
module iodec_match #(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned NUM_WIN  = 3,
   parameter int unsigned WIN_LOG2 = 4,
   parameter logic [ADDR_W-1:0] CFG_LO = '0,
   parameter logic [ADDR_W-1:0] CFG_HI = '0
) (
   input  logic                      addr_in_hi,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_WIN*ADDR_W-1:0] bases,
   output logic [NUM_WIN:0]          hits
);
   localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << WIN_LOG2) - 1);
   localparam logic [ADDR_W-1:0] CFG_MASK = ADDR_W'(1);

   logic [ADDR_W-1:0] cfg_base;
   assign cfg_base = addr_in_hi ? CFG_HI : CFG_LO;
   assign hits[0]  = ((addr ^ cfg_base) & ~CFG_MASK) == '0;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      logic [ADDR_W-1:0] base_k;
      assign base_k    = bases[k*ADDR_W +: ADDR_W];
      assign hits[k+1] = ((addr ^ base_k) & ~WIN_MASK) == '0;
   end
endmodule

// File: rtl/iodec_prio.sv
module iodec_prio #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   // R7: at most one grant, and only to a requester
   always_comb begin
      assert_one_grant_R7: assert ($onehot0(grant) && ((grant & ~req) == '0));
   end
endmodule

// File: rtl/io_qual_decoder.sv
module io_qual_decoder
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W   = IODEC_ADDR_W,
   parameter int unsigned NUM_WIN  = 3,
   parameter int unsigned WIN_LOG2 = IODEC_WIN_LOG2,
   parameter logic [ADDR_W-1:0] CFG_LO = IODEC_CFG_LO,
   parameter logic [ADDR_W-1:0] CFG_HI = IODEC_CFG_HI
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      ior_n,
   input  logic                      iow_n,
   input  logic                      aen,
   input  logic                      cs_n,
   input  logic                      cs_qual_en,
   input  logic                      cfg_strap,
   input  logic [NUM_WIN*ADDR_W-1:0] win_base,
   output logic                      cfg_sel,
   output logic [NUM_WIN-1:0]        win_sel,
   output logic [WIN_LOG2-1:0]       reg_offset
);
   localparam int unsigned NSLOT = NUM_WIN + 1;

   if (WIN_LOG2 < 1 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
      $error("WIN_LOG2 must lie between 1 and ADDR_W-1");
   end
   if (NUM_WIN < 1) begin : g_bad_num
      $error("NUM_WIN must be at least 1");
   end
   if (CFG_LO[0] || CFG_HI[0]) begin : g_bad_cfg
      $error("configuration bases must be even");
   end

   logic              strap_q;
   logic              active;
   logic [ADDR_W-1:0] addr_eff;
   logic [NSLOT-1:0]  hits;
   logic [NSLOT-1:0]  grant;
   logic [NSLOT-1:0]  sel_q;
   logic              qualify;

   iodec_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n),
      .addr(addr), .active(active), .addr_eff(addr_eff)
   );

   iodec_match #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2),
      .CFG_LO(CFG_LO), .CFG_HI(CFG_HI)
   ) u_match (
      .addr_in_hi(strap_q), .addr(addr_eff), .bases(win_base), .hits(hits)
   );

   iodec_prio #(.N(NSLOT)) u_prio (.req(hits), .grant(grant));

   assign qualify = active & ~aen & (~cs_qual_en | ~cs_n);

   always_ff @(posedge clk) begin
      if (rst) begin
         strap_q    <= cfg_strap;
         sel_q      <= '0;
         reg_offset <= '0;
      end else begin
         sel_q      <= qualify ? grant : '0;
         reg_offset <= (qualify && (|grant)) ? addr_eff[WIN_LOG2-1:0] : '0;
      end
   end

   assign cfg_sel = sel_q[SLOT_CFG];
   assign win_sel = sel_q[NSLOT-1:1];

   // R3: DMA cycles select nothing
   assert_dma_block_R3: assert property (@(posedge clk) disable iff (rst)
      aen |=> (sel_q == '0));
   // R4: external select gates decoding when enabled
   assert_ext_sel_R4: assert property (@(posedge clk) disable iff (rst)
      (cs_qual_en && cs_n) |=> (sel_q == '0));
   // R8: no select without a strobe
   assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (ior_n && iow_n) |=> (sel_q == '0 && reg_offset == '0));
   // R5: strap choice held between resets
   assert_strap_hold_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(strap_q));
   // R7: one select at most on the outputs
   assert_single_sel_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({win_sel, cfg_sel}));
endmodule

// File: tb/tb_io_qual_decoder.sv
module tb_io_qual_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [10:0] addr = '0;
   logic        ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0;
   logic        cs_n = 1'b1, cs_qual_en = 1'b0, cfg_strap = 1'b0;
   logic [32:0] win_base = '0;
   logic        cfg_sel;
   logic [2:0]  win_sel;
   logic [3:0]  reg_offset;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [10:0] b0, b1, b2;

   io_qual_decoder dut (
      .clk(clk), .rst(rst), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
      .aen(aen), .cs_n(cs_n), .cs_qual_en(cs_qual_en), .cfg_strap(cfg_strap),
      .win_base(win_base), .cfg_sel(cfg_sel), .win_sel(win_sel),
      .reg_offset(reg_offset)
   );

   always #4 clk = ~clk;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_sel(input int a, input bit s);
      int cb;
      cb = s ? 'h370 : 'h3F0;
      if ((a >> 1) == (cb >> 1)) return 4'b0001;
      if ((a >> 4) == (int'(b0) >> 4)) return 4'b0010;
      if ((a >> 4) == (int'(b1) >> 4)) return 4'b0100;
      if ((a >> 4) == (int'(b2) >> 4)) return 4'b1000;
      return 4'b0000;
   endfunction

   function automatic logic [3:0] outv();
      return {win_sel, cfg_sel};
   endfunction

   task automatic do_reset(input bit s);
      @(negedge clk);
      rst = 1'b1; cfg_strap = ~s;
      @(negedge clk);
      chk(outv() == 0 && reg_offset == 0, "R8 reset outputs", {outv(), reg_offset}, 0);
      cfg_strap = s;
      @(negedge clk);
      rst = 1'b0; cfg_strap = ~s;
   endtask

   task automatic set_bases(input logic [10:0] x0, x1, x2);
      b0 = x0; b1 = x1; b2 = x2;
      win_base = {x2, x1, x0};
   endtask

   // one strobe of one sampled clock, then idle
   task automatic access(input logic [10:0] a, input bit wr, input bit s);
      logic [3:0] e;
      @(negedge clk);
      addr = a;
      if (wr) iow_n = 1'b0; else ior_n = 1'b0;
      @(negedge clk);
      e = exp_sel(a, s);
      chk(outv() == e, "R2/R5/R6/R7 sweep select", outv(), e);
      chk(reg_offset == ((e != 0) ? a[3:0] : 4'd0), "R9 sweep offset", reg_offset,
          (e != 0) ? a[3:0] : 0);
      ior_n = 1'b1; iow_n = 1'b1;
      @(negedge clk);
      chk(outv() == 0, "R8 clear after strobe", outv(), 0);
   endtask

   initial begin
      set_bases(11'h2F8, 11'h2F0, 11'h3F0);
      do_reset(1'b0);
      for (int a = 0; a < 2048; a++) access(11'(a), a[0], 1'b0);

      // R2 explicit alias check
      access(11'h7F0, 1'b0, 1'b0);
      chk(outv() == 0, "R2 bit 10 alias", outv(), 0);

      // R1: address moved mid-strobe keeps first capture
      @(negedge clk); addr = 11'h3F1; ior_n = 1'b0;
      @(negedge clk); addr = 11'h2F5;
      @(negedge clk);
      chk(outv() == 4'b0001 && reg_offset == 4'd1, "R1 hold capture", {outv(), reg_offset}, 'h11);
      // R8 both strobes low act as one
      iow_n = 1'b0;
      @(negedge clk);
      chk(outv() == 4'b0001, "R8 both strobes", outv(), 1);
      ior_n = 1'b1; iow_n = 1'b1;
      @(negedge clk);

      // R3: aen blocks from start and mid-strobe
      @(negedge clk); addr = 11'h3F0; aen = 1'b1; iow_n = 1'b0;
      @(negedge clk);
      chk(outv() == 0, "R3 aen at start", outv(), 0);
      aen = 1'b0;
      @(negedge clk);
      chk(outv() == 4'b0001, "R3 aen dropped", outv(), 1);
      aen = 1'b1;
      @(negedge clk);
      chk(outv() == 0, "R3 aen mid strobe", outv(), 0);
      aen = 1'b0; iow_n = 1'b1;
      @(negedge clk);

      // R4: external select qualification
      cs_qual_en = 1'b1; cs_n = 1'b1;
      @(negedge clk); addr = 11'h2F3; ior_n = 1'b0;
      @(negedge clk);
      chk(outv() == 0, "R4 cs_n high blocks", outv(), 0);
      cs_n = 1'b0;
      @(negedge clk);
      chk(outv() == 4'b0010 && reg_offset == 4'd3, "R4 cs_n low passes", {outv(), reg_offset}, 'h23);
      ior_n = 1'b1; cs_qual_en = 1'b0; cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk); addr = 11'h2F3; ior_n = 1'b0;
      @(negedge clk);
      chk(outv() == 4'b0010, "R4 qualification off ignores cs_n", outv(), 2);
      ior_n = 1'b1;
      @(negedge clk);

      // second strap, new overlap layout
      set_bases(11'h120, 11'h2F0, 11'h370);
      do_reset(1'b1);
      for (int a = 0; a < 2048; a++) access(11'(a), ~a[0], 1'b1);

      // R5: strap toggling after release has no effect
      cfg_strap = 1'b0;
      repeat (3) @(negedge clk);
      access(11'h3F0, 1'b0, 1'b1);
      chk(outv() == 0, "R5 strap ignored after release", outv(), 0);
      @(negedge clk); addr = 11'h371; iow_n = 1'b0;
      @(negedge clk);
      chk(outv() == 4'b0001 && reg_offset == 4'd1, "R5 config data port", {outv(), reg_offset}, 'h11);
      iow_n = 1'b1;
      @(negedge clk);
      summary();
   end
endmodule